// File: doc/BRIEF.md
# Coprocessor Instruction Decode Queue

This block sits at the entry of a coprocessor pipeline. The main core hands it 32-bit instruction words; they are held in a small first-in, first-out queue. The oldest queued word is decoded in place. Words that do not belong to the coprocessor class, and coprocessor words that carry another unit's number, are discarded. Matching words are offered to the issue stage over a valid/enable handshake.

Every instruction that moves to the issue stage is given a sequence tag. When that instruction is a vectored load or store, the block sends the transfer length back to the core. The report is a one-cycle pulse that carries the tag, so the core can pair the length with its instruction.

A single stall input freezes the stage. While it is high, nothing enters the queue, nothing is discarded and nothing leaves.

Top module: `cpdq_top`

## Requirements
- R1: Directly after reset the queue is empty, `in_ready` is 1, `iss_valid` is 0, `len_valid` is 0 and `iss_tag` is 0.
- R2: A word is stored when `in_valid` and `in_ready` are both 1 at a clock edge. Words leave in arrival order. With `DEPTH` (default 4) words held, `in_ready` is 0.
- R3: A word whose bits [27:24] are neither 4'hE (coprocessor operation) nor 4'hC (coprocessor vectored transfer) is discarded from the queue head and never appears on the issue outputs.
- R4: A coprocessor-class word whose bits [11:8] differ from the parameter `CP_NUM` (default 6) is discarded and never appears on the issue outputs.
- R5: A matching word at the queue head is shown on `iss_valid`/`iss_word`. It is removed only at an edge where `iss_en` is 1, and until then it stays unchanged.
- R6: While `stall` is 1, `in_ready` and `iss_valid` are 0. Queue contents do not change and no word is discarded.
- R7: Issued instructions receive tags 0, 1, 2, … in issue order, wrapping at 2^`TAG_W` (default 8). `iss_tag` shows the tag of the word on offer.
- R8: For an issued 4'hC word, `iss_vec` is 1. `len_valid` is 1 for exactly the cycle after the issuing edge. In that cycle `len_tag` carries its tag and `len_count` carries bits [3:0], with field value 0 meaning 16 transfers.
- R9: An issued 4'hE word has `iss_vec` at 0 and produces no length report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Core offers a word |
| in_word | input | 32 | Instruction word from the core |
| in_ready | output | 1 | Queue can take a word this cycle |
| stall | input | 1 | Freezes entry, discard and issue |
| iss_en | input | 1 | Issue stage accepts the offered word |
| iss_valid | output | 1 | A matching instruction is on offer |
| iss_word | output | 32 | Offered instruction word |
| iss_vec | output | 1 | Offered word is a vectored transfer |
| iss_tag | output | TAG_W | Sequence tag of the offered word |
| len_valid | output | 1 | One-cycle length report to the core |
| len_tag | output | TAG_W | Tag the length report belongs to |
| len_count | output | 5 | Vectored transfer length, 1 to 16 |

## Verification
A word stored at edge N is at the head from cycle N+1. If it matches, `iss_valid` rises in that same cycle with no extra register. The word leaves at the first later edge where `iss_en` is high, and its length pulse fills exactly the cycle after that edge. The bench drives inputs one nanosecond after a rising edge and samples at the falling edge. For each offer it observes with `iss_en` high, it pops the next expected word from a scoreboard queue. For each `len_valid` it sees, it pops the next expected report. A discarded word therefore shows up as a wrong order, and a missing or extra pulse shows up as a mismatch or as a leftover entry.

// File: rtl/cpdq_pkg.sv
// Package: field positions and codes shared by the decode queue modules.
// Assumes a 32-bit instruction word with the class marker, unit number and
// length field at fixed bit positions.
package cpdq_pkg;
    localparam int WORD_W    = 32;
    localparam int MARK_LSB  = 24;
    localparam int NUM_LSB   = 8;
    localparam int LEN_LSB   = 0;
    localparam int FIELD_W   = 4;
    localparam int COUNT_W   = FIELD_W + 1;

    localparam logic [FIELD_W-1:0] MARK_OP  = 4'hE;
    localparam logic [FIELD_W-1:0] MARK_VEC = 4'hC;

    typedef enum logic [1:0] {
        CLS_FOREIGN = 2'd0,
        CLS_OP      = 2'd1,
        CLS_VEC     = 2'd2
    } cp_class_e;
endpackage

// File: rtl/cpdq_fifo.sv
// Module: cpdq_fifo
// Circular queue of DEPTH words with read and write pointers and an
// occupancy count. Assumes the caller never writes when full and never
// reads when empty. A read and a write in the same cycle are allowed.
module cpdq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage array write; no reset needed for data.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_en) wp <= step(wp);
            if (rd_en) rp <= step(rp);
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head word and level flags.
    always_comb begin
        rd_data = mem[rp];
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!full || rd_en));
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/cpdq_decoder.sv
// Module: cpdq_decoder
// Purely combinational classification of the head word, taken from its
// marker, unit-number and length fields. Assumes the caller qualifies the
// outputs with queue occupancy.
module cpdq_decoder
    import cpdq_pkg::*;
#(
    parameter logic [FIELD_W-1:0] CP_NUM = 4'd6
) (
    input  logic [FIELD_W-1:0] mark,
    input  logic [FIELD_W-1:0] unit_num,
    input  logic [FIELD_W-1:0] len_field,
    output logic               accept,
    output logic               is_vec,
    output logic [COUNT_W-1:0] len_count
);
    cp_class_e cls;

    // Class from marker, then the unit-number match and the length map.
    always_comb begin
        unique case (mark)
            MARK_OP:  cls = CLS_OP;
            MARK_VEC: cls = CLS_VEC;
            default:  cls = CLS_FOREIGN;
        endcase
        accept    = (cls != CLS_FOREIGN) && (unit_num == CP_NUM);
        is_vec    = (cls == CLS_VEC);
        len_count = (len_field == '0) ? COUNT_W'(1 << FIELD_W)
                                      : {1'b0, len_field};
    end
endmodule

// File: rtl/cpdq_report.sv
// Module: cpdq_report
// Keeps the issue tag counter and registers a one-cycle length report for
// each issued vectored transfer. Assumes 'fire' marks an issuing edge.
module cpdq_report
    import cpdq_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic               fire_vec,
    input  logic [COUNT_W-1:0] fire_len,
    output logic [TAG_W-1:0]   cur_tag,
    output logic               len_valid,
    output logic [TAG_W-1:0]   len_tag,
    output logic [COUNT_W-1:0] len_count
);
    // Tag advance and report pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_tag   <= '0;
            len_valid <= 1'b0;
            len_tag   <= '0;
            len_count <= '0;
        end else begin
            len_valid <= fire && fire_vec;
            if (fire) begin
                cur_tag   <= cur_tag + 1'b1;
                len_tag   <= cur_tag;
                len_count <= fire_len;
            end
        end
    end

    assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cur_tag == TAG_W'($past(cur_tag) + 1'b1)));
    assert_tag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (cur_tag == $past(cur_tag)));
    assert_len_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && !$past(fire)) |-> 1'b0);
endmodule

// File: rtl/cpdq_top.sv
// Module: cpdq_top
// Coprocessor decode queue: stores core words, drops foreign and
// wrong-unit words at the head, offers matching words to the issue stage
// and reports vectored transfer lengths with a tag. Assumes a synchronous
// active-low reset, and that the stall input is meant to freeze entry,
// discard and issue together.
module cpdq_top
    import cpdq_pkg::*;
#(
    parameter int                 DEPTH  = 4,
    parameter int                 TAG_W  = 3,
    parameter logic [FIELD_W-1:0] CP_NUM = 4'd6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               in_ready,
    input  logic               stall,
    input  logic               iss_en,
    output logic               iss_valid,
    output logic [WORD_W-1:0]  iss_word,
    output logic               iss_vec,
    output logic [TAG_W-1:0]   iss_tag,
    output logic               len_valid,
    output logic [TAG_W-1:0]   len_tag,
    output logic [COUNT_W-1:0] len_count
);
    localparam int CW = $clog2(DEPTH + 1);

    logic               push, pop, move, discard;
    logic               q_empty, q_full;
    logic [CW-1:0]      q_count;
    logic [WORD_W-1:0]  head;
    logic               head_ok, head_vec;
    logic [COUNT_W-1:0] head_len;

    cpdq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (in_word),
        .rd_en   (pop),
        .rd_data (head),
        .empty   (q_empty),
        .full    (q_full),
        .count   (q_count)
    );

    cpdq_decoder #(.CP_NUM(CP_NUM)) u_dec (
        .mark      (head[MARK_LSB +: FIELD_W]),
        .unit_num  (head[NUM_LSB +: FIELD_W]),
        .len_field (head[LEN_LSB +: FIELD_W]),
        .accept    (head_ok),
        .is_vec    (head_vec),
        .len_count (head_len)
    );

    cpdq_report #(.TAG_W(TAG_W)) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (move),
        .fire_vec  (head_vec),
        .fire_len  (head_len),
        .cur_tag   (iss_tag),
        .len_valid (len_valid),
        .len_tag   (len_tag),
        .len_count (len_count)
    );

    // Handshake and flow control around the queue head.
    always_comb begin
        in_ready  = !q_full && !stall;
        push      = in_valid && in_ready;
        iss_valid = !stall && !q_empty && head_ok;
        move      = iss_valid && iss_en;
        discard   = !stall && !q_empty && !head_ok;
        pop       = move || discard;
        iss_word  = head;
        iss_vec   = head_vec;
    end

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !in_ready);
    assert_class_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_word[MARK_LSB +: FIELD_W] == MARK_OP ||
                       iss_word[MARK_LSB +: FIELD_W] == MARK_VEC));
    assert_unit_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_word[NUM_LSB +: FIELD_W] == CP_NUM));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_en) |=> (stall || (iss_valid && iss_word == $past(iss_word))));
    assert_stall_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (q_count == $past(q_count)));
    assert_len_after_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> ($past(move) && $past(iss_vec) && len_tag == $past(iss_tag)));
    assert_no_len_for_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (move && !iss_vec) |=> !len_valid);
endmodule

// File: tb/cpdq_top_tb.sv
`timescale 1ns/1ps
module cpdq_top_tb;
    localparam logic [3:0] MY_NUM = 4'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        stall = 1'b0;
    logic        iss_en = 1'b0;
    logic        iss_valid;
    logic [31:0] iss_word;
    logic        iss_vec;
    logic [2:0]  iss_tag;
    logic        len_valid;
    logic [2:0]  len_tag;
    logic [4:0]  len_count;

    int total = 0;
    int bad   = 0;
    int en_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [2:0] exp_tag = '0;
    bit done = 0;

    logic [31:0] q_word[$];
    logic [2:0]  q_tag[$];
    logic        q_vec[$];
    logic [2:0]  q_ltag[$];
    logic [4:0]  q_len[$];

    always #2 clk = ~clk;

    cpdq_top #(.DEPTH(4), .TAG_W(3), .CP_NUM(MY_NUM)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .stall(stall), .iss_en(iss_en),
        .iss_valid(iss_valid), .iss_word(iss_word), .iss_vec(iss_vec),
        .iss_tag(iss_tag), .len_valid(len_valid), .len_tag(len_tag),
        .len_count(len_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] mark, input logic [3:0] num,
                                       input logic [3:0] len, input logic [11:0] pay);
        return {4'h0, mark, pay, num, 4'h0, len};
    endfunction

    // Issue-enable pattern: 0 off, 1 on, 2 pseudo-random.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (en_mode)
            0: iss_en = 1'b0;
            1: iss_en = 1'b1;
            default: iss_en = lfsr[0];
        endcase
    end

    // Driver: offers one word, waits for acceptance, records expectations.
    task automatic send(input logic [31:0] w);
        logic ok;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_word  = w;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        ok = (w[27:24] == 4'hE || w[27:24] == 4'hC) && (w[11:8] == MY_NUM);
        if (ok) begin
            q_word.push_back(w);
            q_tag.push_back(exp_tag);
            q_vec.push_back(w[27:24] == 4'hC);
            if (w[27:24] == 4'hC) begin
                q_ltag.push_back(exp_tag);
                q_len.push_back((w[3:0] == 4'h0) ? 5'd16 : {1'b0, w[3:0]});
            end
            exp_tag = exp_tag + 1'b1;
        end
    endtask

    // Monitor: compares issued words and length reports against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (iss_valid && iss_en) begin
                if (q_word.size() == 0) begin
                    check(0, "R3/R4", "unexpected issue", iss_word, 32'h0);
                end else begin
                    logic [31:0] ew; logic [2:0] et; logic ev;
                    ew = q_word.pop_front(); et = q_tag.pop_front(); ev = q_vec.pop_front();
                    check(iss_word == ew, "R2/R3/R4", "issue order", iss_word, ew);
                    check(iss_tag == et, "R7", "issue tag", {29'h0, iss_tag}, {29'h0, et});
                    check(iss_vec == ev, "R8/R9", "vector flag", {31'h0, iss_vec}, {31'h0, ev});
                end
            end
            if (len_valid) begin
                if (q_len.size() == 0) begin
                    check(0, "R9", "unexpected length report", {27'h0, len_count}, 32'h0);
                end else begin
                    logic [2:0] lt; logic [4:0] ll;
                    lt = q_ltag.pop_front(); ll = q_len.pop_front();
                    check(len_tag == lt, "R8", "length tag", {29'h0, len_tag}, {29'h0, lt});
                    check(len_count == ll, "R8", "length count", {27'h0, len_count}, {27'h0, ll});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready", {31'h0, in_ready}, 32'h1);
        check(iss_valid == 1'b0, "R1", "iss_valid", {31'h0, iss_valid}, 32'h0);
        check(len_valid == 1'b0, "R1", "len_valid", {31'h0, len_valid}, 32'h0);
        check(iss_tag == 3'd0, "R1", "iss_tag", {29'h0, iss_tag}, 32'h0);

        // R2 fill to capacity with issue disabled; R5 hold
        en_mode = 0;
        send(mk(4'hE, MY_NUM, 4'h1, 12'h101));
        send(mk(4'hC, MY_NUM, 4'h3, 12'h102));
        send(mk(4'hE, MY_NUM, 4'h0, 12'h103));
        send(mk(4'hC, MY_NUM, 4'h0, 12'h104));
        @(negedge clk);
        check(in_ready == 1'b0, "R2", "in_ready when full", {31'h0, in_ready}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(iss_valid && iss_word == mk(4'hE, MY_NUM, 4'h1, 12'h101), "R5",
                  "held head", iss_word, mk(4'hE, MY_NUM, 4'h1, 12'h101));
        end
        en_mode = 1;
        repeat (8) @(negedge clk);

        // R3/R4 mixed stream with random issue enable
        en_mode = 2;
        send(mk(4'h2, MY_NUM, 4'h5, 12'h201));
        send(mk(4'hE, 4'd3, 4'h5, 12'h202));
        send(mk(4'hC, MY_NUM, 4'h5, 12'h203));
        send(mk(4'hC, 4'd7, 4'h2, 12'h204));
        send(mk(4'hD, MY_NUM, 4'h1, 12'h205));
        send(mk(4'hE, MY_NUM, 4'h9, 12'h206));
        send(mk(4'hC, MY_NUM, 4'hF, 12'h207));
        send(mk(4'h0, 4'd0, 4'h0, 12'h208));
        send(mk(4'hE, MY_NUM, 4'h2, 12'h209));
        en_mode = 1;
        repeat (10) @(negedge clk);

        // R6 stall with queued words and issue enabled
        en_mode = 0;
        send(mk(4'hC, MY_NUM, 4'h7, 12'h301));
        send(mk(4'h1, MY_NUM, 4'h7, 12'h302));
        send(mk(4'hE, MY_NUM, 4'h4, 12'h303));
        @(posedge clk); #1 stall = 1'b1;
        en_mode = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!iss_valid && !in_ready && !len_valid, "R6", "frozen while stalled",
                  {29'h0, iss_valid, in_ready, len_valid}, 32'h0);
        end
        @(posedge clk); #1 stall = 1'b0;
        repeat (8) @(negedge clk);

        // R7 tag wrap with more issues, R9 ops
        en_mode = 2;
        for (int i = 0; i < 8; i++) begin
            send(mk((i % 2 == 0) ? 4'hE : 4'hC, MY_NUM, 4'(i + 1), 12'(12'h400 + i)));
        end
        en_mode = 1;
        repeat (12) @(negedge clk);

        check(q_word.size() == 0, "R3/R4", "issue scoreboard drained", q_word.size(), 0);
        check(q_len.size() == 0, "R8", "length scoreboard drained", q_len.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule